// File: doc/BRIEF.md
# Fixed-Duty Square-Wave Phase-Accumulator Oscillator

This block produces a 50 % duty square wave whose frequency is set by a 16-bit step value. A 20-bit phase accumulator adds the step on every enabled clock. Each time the sum carries out of the top bit, an internal toggle flips. The output therefore completes one full period every two carries, giving f_out = f_clk × step / 2^21. As an example, a 16 MHz clock with a step of 82 gives roughly 626 Hz, and a step of 111 gives roughly 847 Hz.

Software loads the step one byte at a time. The upper byte is held in a staging register. Writing the lower byte commits both bytes together, so the oscillator never runs on a half-written step. A changed step does not reset the phase.

Around the accumulator sit four more functions:
- a synchronous accumulator clear;
- a polarity select that inverts the pin;
- a level bit that shows the logical (pre-polarity) state of the wave;
- a sticky flag that is set by every carry, whether or not anyone is listening, and is cleared by a dedicated strobe.

Top module: `sqwave_nco`

## Requirements
- R1: While enabled, every carry out of bit 19 of the accumulator (the sum acc + step reaching 2^20) flips the logical wave state on that same clock edge. With a step of 0x4000, the wave therefore changes state exactly once every 64 enabled clocks.
- R2: A pulse on `step_hi_we` with `step_lo_we` low only stages `step_byte`. It leaves the running step, and so the output timing, unchanged.
- R3: A pulse on `step_lo_we` loads the running step as {staged upper byte, `step_byte`}, where the upper byte occupies bits 15:8. The new step is used from the next clock edge onward, and the accumulator keeps its value across the change.
- R4: `acc_clr` sets the accumulator to zero on the next edge, overriding accumulation on that edge. No carry occurs on that edge.
- R5: `ovf_flag` goes to 1 on the edge of any carry, regardless of any other input. It stays at 1 until a `flag_clr` pulse arrives on an edge without a carry, and it then reads 0.
- R6: `wave_level` reads 1 exactly when the block is enabled and the logical wave is high. `wave_out` equals `wave_level` XOR `pol_inv`. Both are registered, so they reflect the inputs of the preceding edge.
- R7: While `en` is low, the accumulator and the wave state hold their values, no carry occurs, and `wave_level` is 0. `wave_out` therefore sits at `pol_inv`.
- R8: After a synchronous reset, the step, the staged byte, the accumulator, the wave state, `ovf_flag`, `wave_level` and `wave_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| pol_inv | input | 1 | Invert the output pin when 1 |
| step_hi_we | input | 1 | Stage `step_byte` as the upper step byte |
| step_lo_we | input | 1 | Commit {staged byte, `step_byte`} as the step |
| step_byte | input | 8 | Step byte write data |
| acc_clr | input | 1 | Clear the phase accumulator |
| flag_clr | input | 1 | Clear the sticky carry flag |
| wave_out | output | 1 | Square wave after polarity |
| wave_level | output | 1 | Logical wave state (1 = high) |
| ovf_flag | output | 1 | Sticky carry flag |

## Verification
All three outputs are registered one edge after the inputs that cause them. A carry, a clear or a committed step is visible at the output registers at the same edge at which the accumulator updates. A step committed at edge k first shapes the sum at edge k+1.

The bench drives the inputs at the falling edge. It advances a reference model from the requirements just after each rising edge and compares the outputs 1 ns later, so every comparison lands on the cycle in which the result is due. Directed sequences then count wave transitions over known windows to confirm the step period, the staging rule and the phase hold while disabled.

// File: rtl/sqwave_nco_pkg.sv
package sqwave_nco_pkg;
  parameter int unsigned NCO_ACC_W = 20;
  parameter int unsigned NCO_STEP_W = 16;

  // Zero-extend a step value to the accumulator width.
  function automatic logic [NCO_ACC_W-1:0] widen_step(input logic [NCO_STEP_W-1:0] s);
    return {{(NCO_ACC_W-NCO_STEP_W){1'b0}}, s};
  endfunction
endpackage

// File: rtl/nco_step_buf.sv
module nco_step_buf #(
  parameter int unsigned STEP_W = 16,
  localparam int unsigned HALF_W = STEP_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [HALF_W-1:0] wdata,
  output logic [STEP_W-1:0] step_q
);
  logic [HALF_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      step_q  <= '0;
    end else begin
      if (hi_we) stage_q <= wdata;
      if (lo_we) step_q <= {stage_q, wdata};
    end
  end

  p_hi_stage_only_r2: assert property (@(posedge clk) disable iff (rst)
    (hi_we && !lo_we) |=> $stable(step_q));
  p_lo_commit_r3: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> (step_q[HALF_W-1:0] == $past(wdata)));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import sqwave_nco_pkg::*;
#(
  parameter int unsigned ACC_W = NCO_ACC_W,
  parameter int unsigned STEP_W = NCO_STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  input  logic [STEP_W-1:0] step,
  output logic              carry
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, {{(ACC_W-STEP_W){1'b0}}, step}};
    carry = en && !clr && sum[ACC_W];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else if (en)    acc_q <= sum[ACC_W-1:0];
  end

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0));
  p_hold_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(acc_q));
  p_no_carry_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!en || clr) |-> !carry);
endmodule

// File: rtl/nco_wave_out.sv
module nco_wave_out (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pol_inv,
  input  logic carry,
  input  logic flag_clr,
  output logic wave_q,
  output logic level_q,
  output logic flag_q
);
  logic tog_q;
  logic tog_d;

  always_comb tog_d = tog_q ^ carry;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q   <= 1'b0;
      level_q <= 1'b0;
      wave_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      tog_q   <= tog_d;
      level_q <= en & tog_d;
      wave_q  <= (en & tog_d) ^ pol_inv;
      flag_q  <= (flag_q & ~flag_clr) | carry;
    end
  end

  p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
    carry |=> flag_q);
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q);
  p_inactive_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!level_q && (wave_q == $past(pol_inv))));
  p_toggle_r1: assert property (@(posedge clk) disable iff (rst)
    (en && carry && $past(en) && !rst) |=> (level_q != $past(level_q)));
endmodule

// File: rtl/sqwave_nco.sv
module sqwave_nco
  import sqwave_nco_pkg::*;
#(
  parameter int unsigned ACC_W = NCO_ACC_W,
  parameter int unsigned STEP_W = NCO_STEP_W,
  localparam int unsigned HALF_W = STEP_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pol_inv,
  input  logic              step_hi_we,
  input  logic              step_lo_we,
  input  logic [HALF_W-1:0] step_byte,
  input  logic              acc_clr,
  input  logic              flag_clr,
  output logic              wave_out,
  output logic              wave_level,
  output logic              ovf_flag
);
  logic [STEP_W-1:0] step;
  logic              carry;

  nco_step_buf #(.STEP_W(STEP_W)) i_step (
    .clk(clk), .rst(rst), .hi_we(step_hi_we), .lo_we(step_lo_we),
    .wdata(step_byte), .step_q(step));

  nco_phase_acc #(.ACC_W(ACC_W), .STEP_W(STEP_W)) i_acc (
    .clk(clk), .rst(rst), .en(en), .clr(acc_clr), .step(step), .carry(carry));

  nco_wave_out i_out (
    .clk(clk), .rst(rst), .en(en), .pol_inv(pol_inv), .carry(carry),
    .flag_clr(flag_clr), .wave_q(wave_out), .level_q(wave_level), .flag_q(ovf_flag));

  p_pol_relation_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wave_out == (wave_level ^ $past(pol_inv))));
endmodule

// File: tb/test_sqwave_nco.sv
module test_sqwave_nco;
  logic clk = 1'b0;
  logic rst, en, pol_inv, step_hi_we, step_lo_we, acc_clr, flag_clr;
  logic [7:0] step_byte;
  logic wave_out, wave_level, ovf_flag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference model state
  logic [7:0]  m_stage;
  logic [15:0] m_step;
  logic [19:0] m_acc;
  logic        m_tog, m_level, m_wave, m_flag;

  always #5 clk = ~clk;

  sqwave_nco i_sqwave_nco (
    .clk(clk), .rst(rst), .en(en), .pol_inv(pol_inv),
    .step_hi_we(step_hi_we), .step_lo_we(step_lo_we), .step_byte(step_byte),
    .acc_clr(acc_clr), .flag_clr(flag_clr),
    .wave_out(wave_out), .wave_level(wave_level), .ovf_flag(ovf_flag));

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog expired actual=%0d expected<=150000 cycles", cycles);
      failures = failures + 1;
      summary_and_end();
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic logic [20:0] add_step(input logic [19:0] a, input logic [15:0] s);
    return {1'b0, a} + {5'b0, s};
  endfunction

  // One clock: drive at negedge, advance the model after posedge, compare.
  task automatic step(input logic e, input logic p, input logic hw, input logic lw,
                      input logic [7:0] b, input logic ac, input logic fc);
    logic [20:0] s;
    logic        c;
    @(negedge clk);
    en = e; pol_inv = p; step_hi_we = hw; step_lo_we = lw;
    step_byte = b; acc_clr = ac; flag_clr = fc;
    @(posedge clk);
    #1;
    c = 1'b0;
    if (ac) m_acc = '0;
    else if (e) begin
      s = add_step(m_acc, m_step);
      c = s[20];
      m_acc = s[19:0];
    end
    // R3: commit uses the stage held before this edge; new step used from next edge
    if (lw) m_step = {m_stage, b};
    if (hw) m_stage = b;
    m_tog   = m_tog ^ c;
    m_flag  = (m_flag & ~fc) | c;
    m_level = e & m_tog;
    m_wave  = m_level ^ p;
    chk("R6 wave_level", wave_level, m_level);
    chk("R6 wave_out polarity", wave_out, m_wave);
    chk("R5 ovf_flag", ovf_flag, m_flag);
  endtask

  task automatic load_step(input logic [15:0] v, input logic p);
    step(1'b0, p, 1'b1, 1'b0, v[15:8], 1'b0, 1'b0);
    step(1'b0, p, 1'b0, 1'b1, v[7:0], 1'b0, 1'b0);
  endtask

  // run n enabled cycles, return number of wave_level transitions
  task automatic run_count(input int n, input logic p, output int tr);
    logic last;
    tr = 0;
    last = wave_level;
    for (int i = 0; i < n; i++) begin
      step(1'b1, p, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
      if (wave_level != last) tr++;
      last = wave_level;
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    int tr;
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst = 1'b1; en = 0; pol_inv = 0; step_hi_we = 0; step_lo_we = 0;
    step_byte = 0; acc_clr = 0; flag_clr = 0;
    m_stage = 0; m_step = 0; m_acc = 0; m_tog = 0; m_level = 0; m_wave = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    chk("R8 reset wave_out", wave_out, 1'b0);
    chk("R8 reset wave_level", wave_level, 1'b0);
    chk("R8 reset ovf_flag", ovf_flag, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R1: step 0x4000 -> one transition per 64 enabled clocks
    load_step(16'h4000, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    run_count(1280, 1'b0, tr);
    chk_int("R1 transitions over 1280 clocks step 0x4000", tr, 20);

    // R2: staging the upper byte alone keeps the period
    step(1'b1, 1'b0, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0);
    run_count(640, 1'b0, tr);
    chk_int("R2 hi-only write keeps period", tr, 10);

    // R3: low write commits 0x8000 (32 clocks per transition), phase kept
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
    run_count(640, 1'b0, tr);
    chk_int("R3 committed step 0x8000 transitions", tr, 20);

    // R7: disable mid-period holds phase; next toggle after remaining 22 clocks
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    run_count(10, 1'b0, tr);
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R7 disabled wave_out at polarity", wave_out, 1'b1);
    chk("R7 disabled wave_level low", wave_level, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    run_count(20, 1'b0, tr);
    chk_int("R7 no transition before held phase completes", tr, 0);
    run_count(2, 1'b0, tr);
    chk_int("R7 transition when held phase completes", tr, 1);

    // R5: clear with simultaneous carry keeps the flag; clear alone drops it
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    for (int i = 0; i < 31; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R5 carry wins over clear", ovf_flag, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R5 clear alone drops flag", ovf_flag, 1'b0);

    // R4: clear overrides accumulation
    load_step(16'hFFFF, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk("R4 no carry while clearing", ovf_flag, 1'b0);

    // Random mix checked against the model
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic hw, lw;
      r = $urandom_range(99);
      hw = (r < 3);
      lw = (r >= 3 && r < 6);
      step($urandom_range(99) < 90, $urandom_range(99) < 15, hw, lw,
           8'($urandom_range(255)), $urandom_range(99) < 2, $urandom_range(99) < 10);
    end

    summary_and_end();
  end
endmodule